// File: doc/BRIEF.md
# Binary64 Round and Pack Unit

This unit takes an unpacked double-precision value and turns it into a packed 64-bit binary64 word. The value arrives as a sign, a two's-complement unbiased exponent and a 56-bit mantissa. In the mantissa, bit 55 is the hidden integer bit, bits 54..3 are the 52 fraction bits, and bits 2..0 are three extra low-order bits: guard, round and sticky. The mantissa must be non-zero and must have its hidden bit set. An arithmetic datapath places this unit at its tail to do the final rounding, denormalisation and range handling.

A 2-bit mode input picks the rounding direction. Two more controls are available. One flushes tiny values to zero, or to the smallest denormal, depending on the mode. The other, the underflow-trap enable, makes exact tiny results report underflow. The unit outputs the packed word together with inexact, underflow and overflow flags. All outputs are registered, so a result appears one clock after its inputs.

Exact zeros, NaNs and exception trapping are handled by the surrounding datapath, not by this unit.

Top module: `b64_round_pack`

## Requirements
- R1: A synchronous active-high reset clears the word and all three flags. Otherwise the outputs reflect the inputs sampled at the previous rising clock edge.
- R2: Rounding mode encoding is 0 = nearest-even, 1 = toward zero, 2 = toward +infinity and 3 = toward -infinity. A value is inexact when any of mantissa bits 2..0 is set. In nearest-even mode, a half-way value rounds to the neighbour whose fraction LSB is 0. The directed modes add one ULP only when the sign points in the rounding direction.
- R3: If rounding carries out of bit 55, the mantissa is renormalised and the exponent goes up by one. This can push a value into overflow.
- R4: If the exponent after rounding is above 1023, the overflow and inexact flags are set. Mode 0 gives a signed infinity and mode 1 gives the signed largest finite value. Mode 2 gives +infinity for positive values and the most negative finite value for negative values. Mode 3 gives the largest finite value for positive values and -infinity for negative values. The exact largest finite value is not an overflow.
- R5: With flush enabled and the exponent below -1022, the underflow and inexact flags are set. Modes 0 and 1 give a signed zero. Mode 2 gives the smallest positive denormal for positive values and -0 for negative values. Mode 3 gives -min-denormal for negative values and +0 for positive values. Flush has no effect at exponent -1022.
- R6: Without flush, a value with exponent below -1022 is shifted right by (-1022 - exponent), with shifted-out bits ORed into bit 0. It is then rounded and packed with biased exponent 0, or with biased exponent 1 if rounding sets the hidden bit.
- R7: A denormalising shift of 56 or more reduces the mantissa to a single sticky bit in bit 0.
- R8: At exponent -1023, if rounding the unshifted mantissa carries out of bit 55, the result is the normal value with biased exponent 1. Inexact is set and underflow is clear.
- R9: Underflow is set when the value is inexact and the hidden bit is clear before the final rounding. This also applies when rounding then lifts the value to biased exponent 1.
- R10: An exact result with biased exponent 0 sets underflow only when the underflow-trap enable is set. Normal results never set underflow.
- R11: A normal result is packed as the sign, the biased exponent (exponent + 1023) and the 52 fraction bits, with the hidden bit dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 13 | Unbiased exponent, two's complement |
| in_mant | input | 56 | Hidden bit 55, fraction 54..3, extra bits 2..0 |
| in_rmode | input | 2 | Rounding mode (0 nearest, 1 zero, 2 up, 3 down) |
| flush_en | input | 1 | Flush tiny values |
| uf_trap_en | input | 1 | Report underflow for exact tiny results |
| out_word | output | 64 | Packed binary64 result |
| out_inexact | output | 1 | Inexact flag |
| out_underflow | output | 1 | Underflow flag |
| out_overflow | output | 1 | Overflow flag |

## Verification
Some properties are checked by assertions on every clock cycle:
- An overflow always yields either the all-ones exponent or the largest-finite pattern.
- Any input with non-zero extra bits sets inexact (unless flush is enabled).
- A flushed input always raises both underflow and inexact.
- With the trap enabled, a zero-exponent output always reports underflow.
- The rounding carry only comes from an all-ones significand.
- The sticky shifter never loses a non-zero value.

Other behaviours can only be shown by the bench scenarios with their exact expected words:
- the rounding direction in each mode, including half-way ties;
- the mode-specific choice of saturation and flush values;
- the special exponent -1023 path;
- rounding from denormal up into the normal range.

// File: rtl/rp_pkg.sv
package rp_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;
endpackage

// File: rtl/rp_rnd_inc.sv
// Rounding increment on a mantissa that carries three extra low bits.
module rp_rnd_inc #(
  parameter int W = 56
) (
  input  logic         sgn,
  input  logic [1:0]   rm,
  input  logic [W-1:0] m_in,
  output logic [W:0]   m_out,
  output logic         lost
);
  import rp_pkg::*;

  localparam logic [W:0] ULP     = (W+1)'(8);
  localparam logic [W:0] HALF_LO = (W+1)'(3);

  logic [W:0] inc;

  always_comb begin
    lost = |m_in[2:0];
    inc  = '0;
    if (lost) begin
      case (rmode_e'(rm))
        RM_NEAR: inc = HALF_LO + (W+1)'(m_in[3]);
        RM_UP:   if (!sgn) inc = ULP;
        RM_DOWN: if (sgn) inc = ULP;
        default: inc = '0;
      endcase
    end
    m_out = {1'b0, m_in} + inc;
  end

  always_comb begin
    // R3
    carry_src_chk: assert (!m_out[W] || (&m_in[W-1:3]));
  end
endmodule

// File: rtl/rp_sticky_shr.sv
// Right shift that ORs every shifted-out bit into bit 0.
module rp_sticky_shr #(
  parameter int W  = 56,
  parameter int SW = 15
) (
  input  logic [W-1:0]  d,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  q
);
  localparam logic [SW-1:0] LIMIT = SW'(W);

  logic [W-1:0] drop_mask;

  always_comb begin
    drop_mask = ~({W{1'b1}} << amt);
    if (amt >= LIMIT)
      q = {{(W-1){1'b0}}, |d};
    else
      q = (d >> amt) | {{(W-1){1'b0}}, |(d & drop_mask)};
  end

  always_comb begin
    // R7
    sticky_nz_chk: assert ((|q) == (|d));
  end
endmodule

// File: rtl/rp_special_sel.sv
// Mode-dependent saturation and flush words.
module rp_special_sel #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                    sgn,
  input  logic [1:0]              rm,
  output logic [EXP_W+FRAC_W:0]   ovf_word,
  output logic [EXP_W+FRAC_W:0]   flush_word
);
  import rp_pkg::*;

  logic [EXP_W+FRAC_W:0] inf_w, big_w, zero_w, tiny_w;

  always_comb begin
    inf_w  = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    big_w  = {sgn, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    zero_w = {sgn, {(EXP_W+FRAC_W){1'b0}}};
    tiny_w = {sgn, {(EXP_W+FRAC_W-1){1'b0}}, 1'b1};
    case (rmode_e'(rm))
      RM_NEAR: begin ovf_word = inf_w; flush_word = zero_w; end
      RM_ZERO: begin ovf_word = big_w; flush_word = zero_w; end
      RM_UP: begin
        ovf_word   = sgn ? big_w : inf_w;
        flush_word = sgn ? zero_w : tiny_w;
      end
      default: begin
        ovf_word   = sgn ? inf_w : big_w;
        flush_word = sgn ? tiny_w : zero_w;
      end
    endcase
  end
endmodule

// File: rtl/b64_round_pack.sv
module b64_round_pack #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int XE_W   = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_sign,
  input  logic [XE_W-1:0]          in_exp,
  input  logic [FRAC_W+3:0]        in_mant,
  input  logic [1:0]               in_rmode,
  input  logic                     flush_en,
  input  logic                     uf_trap_en,
  output logic [EXP_W+FRAC_W:0]    out_word,
  output logic                     out_inexact,
  output logic                     out_underflow,
  output logic                     out_overflow
);
  localparam int MW   = FRAC_W + 4;
  localparam int DW   = 1 + EXP_W + FRAC_W;
  localparam int XW   = XE_W + 2;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EMIN = 1 - BIAS;
  localparam int EMAX = BIAS;
  localparam logic signed [XW-1:0] EMIN_X = XW'(EMIN);
  localparam logic signed [XW-1:0] EMAX_X = XW'(EMAX);
  localparam logic signed [XW-1:0] BIAS_X = XW'(BIAS);

  logic signed [XW-1:0] e_in, e1, e2;
  logic [XW-1:0]        sh_amt, be;
  logic                 tiny, near_carry, pre_inx, pre_lost, post_lost;
  logic [MW:0]          pre_sum, post_sum;
  logic [MW-1:0]        shifted, m1, m2;
  logic [FRAC_W:0]      sig;
  logic                 carry, uf_pre, over;
  logic [DW-1:0]        ovf_word, flush_word, nxt_word;
  logic                 nxt_inx, nxt_uf, nxt_of;

  assign e_in   = XW'($signed(in_exp));
  assign tiny   = e_in < EMIN_X;
  assign sh_amt = $unsigned(EMIN_X - e_in);

  // Rounding of the unshifted mantissa, used only for the EMIN-1 carry case
  rp_rnd_inc #(.W(MW)) u_rnd_pre (
    .sgn(in_sign), .rm(in_rmode), .m_in(in_mant), .m_out(pre_sum), .lost(pre_lost)
  );

  rp_sticky_shr #(.W(MW), .SW(XW)) u_shr (
    .d(in_mant), .amt(sh_amt), .q(shifted)
  );

  assign near_carry = (e_in == EMIN_X - XW'(1)) && pre_lost && pre_sum[MW];

  always_comb begin
    pre_inx = 1'b0;
    if (!tiny) begin
      m1 = in_mant;
      e1 = e_in;
    end else if (near_carry) begin
      m1      = {pre_sum[MW:4], 3'b000};
      e1      = EMIN_X;
      pre_inx = 1'b1;
    end else begin
      m1 = shifted;
      e1 = EMIN_X;
    end
  end

  rp_rnd_inc #(.W(MW)) u_rnd_main (
    .sgn(in_sign), .rm(in_rmode), .m_in(m1), .m_out(post_sum), .lost(post_lost)
  );

  rp_special_sel #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_spec (
    .sgn(in_sign), .rm(in_rmode), .ovf_word(ovf_word), .flush_word(flush_word)
  );

  always_comb begin
    carry  = post_sum[MW];
    m2     = carry ? post_sum[MW:1] : post_sum[MW-1:0];
    e2     = carry ? e1 + XW'(1) : e1;
    sig    = m2[MW-1:3];
    uf_pre = post_lost & ~m1[MW-1];
    over   = e2 > EMAX_X;
    be     = $unsigned(e2 + BIAS_X);
    if (flush_en && tiny) begin
      nxt_word = flush_word;
      nxt_inx  = 1'b1;
      nxt_uf   = 1'b1;
      nxt_of   = 1'b0;
    end else if (over) begin
      nxt_word = ovf_word;
      nxt_inx  = 1'b1;
      nxt_uf   = 1'b0;
      nxt_of   = 1'b1;
    end else begin
      nxt_inx  = pre_inx | post_lost;
      nxt_of   = 1'b0;
      nxt_uf   = uf_pre | (uf_trap_en & ~sig[FRAC_W]);
      nxt_word = {in_sign, (sig[FRAC_W] ? be[EXP_W-1:0] : {EXP_W{1'b0}}), sig[FRAC_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word      <= '0;
      out_inexact   <= 1'b0;
      out_underflow <= 1'b0;
      out_overflow  <= 1'b0;
    end else begin
      out_word      <= nxt_word;
      out_inexact   <= nxt_inx;
      out_underflow <= nxt_uf;
      out_overflow  <= nxt_of;
    end
  end

  // R4
  ovf_shape_chk: assert property (@(posedge clk) disable iff (rst)
    out_overflow |-> ((&out_word[DW-2:FRAC_W]) ||
      ((out_word[DW-2:FRAC_W] == {{(EXP_W-1){1'b1}}, 1'b0}) && (&out_word[FRAC_W-1:0]))));

  // R2
  grs_inx_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!flush_en && (|in_mant[2:0]))) |-> out_inexact);

  // R5
  flush_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flush_en && tiny)) |-> (out_underflow && out_inexact));

  // R10
  trap_uf_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(uf_trap_en) && (out_word[DW-2:FRAC_W] == '0)) |-> out_underflow);
endmodule

// File: tb/b64_round_pack_tb.sv
module b64_round_pack_tb;
  timeunit 1ns;
  timeprecision 1ps;

  typedef struct packed {
    logic        s;
    logic [12:0] e;
    logic [55:0] m;
    logic [1:0]  rm;
    logic        fl;
    logic        tr;
    logic [63:0] res;
    logic [2:0]  flg;   // {overflow, underflow, inexact}
    logic [7:0]  req;
  } vec_t;

  localparam logic [55:0] ONE  = 56'h80000000000000;
  localparam logic [55:0] ALL1 = 56'hFFFFFFFFFFFFFF;
  localparam logic [55:0] MAXM = 56'hFFFFFFFFFFFFF8;
  localparam int NV = 37;

  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 13'd0,    ONE,                  2'd0, 1'b0, 1'b0, 64'h3FF0000000000000, 3'b000, 8'd11}, // R11
    '{1'b1, 13'd1,    56'hC0000000000000,   2'd0, 1'b0, 1'b0, 64'hC008000000000000, 3'b000, 8'd11}, // R11
    '{1'b0, 13'd0,    56'h80000000000004,   2'd0, 1'b0, 1'b0, 64'h3FF0000000000000, 3'b001, 8'd2},  // R2 tie even
    '{1'b0, 13'd0,    56'h8000000000000C,   2'd0, 1'b0, 1'b0, 64'h3FF0000000000002, 3'b001, 8'd2},  // R2 tie odd
    '{1'b0, 13'd0,    56'h80000000000005,   2'd0, 1'b0, 1'b0, 64'h3FF0000000000001, 3'b001, 8'd2},  // R2
    '{1'b0, 13'd0,    56'h80000000000007,   2'd1, 1'b0, 1'b0, 64'h3FF0000000000000, 3'b001, 8'd2},  // R2
    '{1'b0, 13'd0,    56'h80000000000001,   2'd2, 1'b0, 1'b0, 64'h3FF0000000000001, 3'b001, 8'd2},  // R2
    '{1'b1, 13'd0,    56'h80000000000001,   2'd2, 1'b0, 1'b0, 64'hBFF0000000000000, 3'b001, 8'd2},  // R2
    '{1'b1, 13'd0,    56'h80000000000001,   2'd3, 1'b0, 1'b0, 64'hBFF0000000000001, 3'b001, 8'd2},  // R2
    '{1'b0, 13'd0,    56'h80000000000001,   2'd3, 1'b0, 1'b0, 64'h3FF0000000000000, 3'b001, 8'd2},  // R2
    '{1'b0, 13'd0,    ALL1,                 2'd0, 1'b0, 1'b0, 64'h4000000000000000, 3'b001, 8'd3},  // R3
    '{1'b0, 13'd1024, ONE,                  2'd0, 1'b0, 1'b0, 64'h7FF0000000000000, 3'b101, 8'd4},  // R4
    '{1'b0, 13'd1024, ONE,                  2'd1, 1'b0, 1'b0, 64'h7FEFFFFFFFFFFFFF, 3'b101, 8'd4},  // R4
    '{1'b1, 13'd1024, ONE,                  2'd2, 1'b0, 1'b0, 64'hFFEFFFFFFFFFFFFF, 3'b101, 8'd4},  // R4
    '{1'b1, 13'd1024, ONE,                  2'd3, 1'b0, 1'b0, 64'hFFF0000000000000, 3'b101, 8'd4},  // R4
    '{1'b0, 13'd1024, ONE,                  2'd2, 1'b0, 1'b0, 64'h7FF0000000000000, 3'b101, 8'd4},  // R4
    '{1'b0, 13'd1024, ONE,                  2'd3, 1'b0, 1'b0, 64'h7FEFFFFFFFFFFFFF, 3'b101, 8'd4},  // R4
    '{1'b0, 13'd1023, ALL1,                 2'd0, 1'b0, 1'b0, 64'h7FF0000000000000, 3'b101, 8'd3},  // R3
    '{1'b0, 13'd1023, MAXM,                 2'd0, 1'b0, 1'b0, 64'h7FEFFFFFFFFFFFFF, 3'b000, 8'd4},  // R4
    '{1'b0, -13'sd1023, ONE,                2'd0, 1'b1, 1'b0, 64'h0000000000000000, 3'b011, 8'd5},  // R5
    '{1'b0, -13'sd1100, ONE,                2'd2, 1'b1, 1'b0, 64'h0000000000000001, 3'b011, 8'd5},  // R5
    '{1'b1, -13'sd1100, ONE,                2'd2, 1'b1, 1'b0, 64'h8000000000000000, 3'b011, 8'd5},  // R5
    '{1'b1, -13'sd1100, ONE,                2'd3, 1'b1, 1'b0, 64'h8000000000000001, 3'b011, 8'd5},  // R5
    '{1'b0, -13'sd1100, ONE,                2'd3, 1'b1, 1'b0, 64'h0000000000000000, 3'b011, 8'd5},  // R5
    '{1'b1, -13'sd1023, ONE,                2'd1, 1'b1, 1'b0, 64'h8000000000000000, 3'b011, 8'd5},  // R5
    '{1'b0, -13'sd1022, ONE,                2'd0, 1'b1, 1'b0, 64'h0010000000000000, 3'b000, 8'd5},  // R5
    '{1'b0, -13'sd1023, ONE,                2'd0, 1'b0, 1'b0, 64'h0008000000000000, 3'b000, 8'd6},  // R6
    '{1'b0, -13'sd1023, ONE,                2'd0, 1'b0, 1'b1, 64'h0008000000000000, 3'b010, 8'd10}, // R10
    '{1'b0, -13'sd1023, 56'h80000000000008, 2'd0, 1'b0, 1'b0, 64'h0008000000000000, 3'b011, 8'd9},  // R9
    '{1'b0, -13'sd1023, ALL1,               2'd0, 1'b0, 1'b0, 64'h0010000000000000, 3'b001, 8'd8},  // R8
    '{1'b0, -13'sd1023, ALL1,               2'd1, 1'b0, 1'b0, 64'h000FFFFFFFFFFFFF, 3'b011, 8'd9},  // R9
    '{1'b0, -13'sd1023, MAXM,               2'd0, 1'b0, 1'b0, 64'h0010000000000000, 3'b011, 8'd9},  // R9
    '{1'b0, -13'sd1200, ONE,                2'd2, 1'b0, 1'b0, 64'h0000000000000001, 3'b011, 8'd7},  // R7
    '{1'b0, -13'sd1200, ONE,                2'd0, 1'b0, 1'b0, 64'h0000000000000000, 3'b011, 8'd7},  // R7
    '{1'b0, -13'sd1074, ONE,                2'd0, 1'b0, 1'b0, 64'h0000000000000001, 3'b000, 8'd6},  // R6
    '{1'b0, -13'sd1074, ONE,                2'd0, 1'b0, 1'b1, 64'h0000000000000001, 3'b010, 8'd10}, // R10
    '{1'b0, -13'sd1022, ONE,                2'd0, 1'b0, 1'b1, 64'h0010000000000000, 3'b000, 8'd10}  // R10
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        in_sign;
  logic [12:0] in_exp;
  logic [55:0] in_mant;
  logic [1:0]  in_rmode;
  logic        flush_en, uf_trap_en;
  logic [63:0] out_word;
  logic        out_inexact, out_underflow, out_overflow;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  b64_round_pack u_dut (
    .clk(clk), .rst(rst), .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
    .in_rmode(in_rmode), .flush_en(flush_en), .uf_trap_en(uf_trap_en),
    .out_word(out_word), .out_inexact(out_inexact), .out_underflow(out_underflow),
    .out_overflow(out_overflow)
  );

  task automatic check(input string tag, input logic [66:0] act, input logic [66:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_sign    = v.s;
    in_exp     = v.e;
    in_mant    = v.m;
    in_rmode   = v.rm;
    flush_en   = v.fl;
    uf_trap_en = v.tr;
  endtask

  function automatic logic [66:0] outs();
    return {out_word, out_overflow, out_underflow, out_inexact};
  endfunction

  initial begin
    rst = 1'b1;
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    check("R1 reset state", outs(), 67'd0);
    rst = 1'b0;
    // R1 one-cycle latency: no change before the edge, result after it
    @(negedge clk);
    drive(VECS[11]);
    #1;
    check("R1 hold before edge", outs(), {VECS[0].res, VECS[0].flg});
    @(negedge clk);
    check("R1 after one edge", outs(), {VECS[11].res, VECS[11].flg});
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), outs(), {VECS[i].res, VECS[i].flg});
    end
    // R1 reset while inputs overflow
    drive(VECS[11]);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-run", outs(), 67'd0);
    rst = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000ns;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule